// File: doc/BRIEF.md
# Periodic DMA Transfer Mask Gate

This block sits in the write-packet path of an inter-processor DMA engine and holds back new packets during programmed, repeating time windows. Each window is defined by a start time, an end time and a repeat period, all measured against a local free-running nanosecond counter that enters the block as an input. Firmware programs the period and the two times once. After that, the hardware moves the window forward by one period each time the counter passes its end time, so the ban recurs every control cycle with no further register writes.

The packet stream passes through with start-of-packet and end-of-packet markers and a valid/ready handshake. While any enabled window is active, a beat that would start a new packet is refused: ready to the source and valid to the sink are both held low. A packet that has already started always runs to its end marker, because a packet cannot be cut part way through. The worst-case delay from a window opening to the stream actually stopping is therefore one packet. When every window has closed, traffic resumes on its own.

Top module: `dma_window_gate`

## Requirements
- R1: With no window active, the stream passes through unchanged: outValid equals inValid, inReady equals outReady, and the data and both markers are copied.
- R2: A window is active when the counter value is at or after its start time and before its end time. While a window is active, a beat marked start-of-packet that arrives outside a packet is held: inReady and outValid are both 0.
- R3: Once a start-of-packet beat without the end marker has been accepted, every following beat, up to and including the end-of-packet beat, passes on outReady alone, whatever the window state.
- R4: Blocking stops by itself in the cycle where the counter reaches the window's end time.
- R5: On each clock edge at which an armed window's end time is not after the counter, both its start and end times advance by its period, so the window opens again one period later with no register write.
- R6: Start and end comparisons use the sign bit of the counter minus the stored time, so a window that straddles counter rollover works, and values more than half the counter range away do not match.
- R7: Several windows act independently; the stream is blocked when any of them is active.
- R8: Bit 0 of configuration register 0 is the global enable, cleared by reset; while it is 0 no window blocks and none advances.
- R9: A window whose period register is 0 never blocks and never advances.
- R10: After reset every window register is 0, the global enable is clear and no packet counts as started, so a start-of-packet beat is accepted as soon as the sink is ready.
- R11: Configuration writes use cfgWe, cfgAddr and cfgWdata. Window k is at register address 1+3k for the period, 1+3k+1 for the start time and 1+3k+2 for the end time. A write takes effect at the clock edge where cfgWe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frc | input | TIME_W | Local free-running nanosecond counter |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | ADDR_W | Configuration register address |
| cfgWdata | input | TIME_W | Configuration write data |
| inValid | input | 1 | Source beat valid |
| inData | input | DATA_W | Source beat data |
| inSop | input | 1 | Source beat starts a packet |
| inEop | input | 1 | Source beat ends a packet |
| inReady | output | 1 | Beat accepted from the source |
| outValid | output | 1 | Sink beat valid |
| outData | output | DATA_W | Sink beat data |
| outSop | output | 1 | Sink beat starts a packet |
| outEop | output | 1 | Sink beat ends a packet |
| outReady | input | 1 | Sink can take a beat |

## Verification
The bench builds the block with a 32-bit counter, two windows and 16-bit data, so the two-window OR and the register offsets of the second window can both be exercised. Because the bench drives the counter itself instead of letting it tick, it can jump directly to the exact start and end edges of a window, to a point one period later to see the re-arm, and to both sides of the 32-bit rollover for a window that straddles it.

// File: rtl/dma_window_gate_pkg.sv
package dma_window_gate_pkg;

  // Strobes from the window control to the stream datapath.
  typedef struct packed {
    logic block;   // some enabled window is active now
  } gateCtl_t;

endpackage

// File: rtl/window_slot.sv
// One repeating ban window: period, start and end registers with
// sign-bit comparison against the local counter and self re-arm.
module window_slot #(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [TIME_W-1:0] frc,
  input  logic              wrPeriod,
  input  logic              wrStart,
  input  logic              wrEnd,
  input  logic [TIME_W-1:0] wrData,
  output logic              active
);

  logic [TIME_W-1:0] periodQ;
  logic [TIME_W-1:0] startQ;
  logic [TIME_W-1:0] endQ;
  logic [TIME_W-1:0] sinceStart;
  logic [TIME_W-1:0] sinceEnd;
  logic              armed;
  logic              beforeStart;
  logic              beforeEnd;
  logic              rearm;

  // Differences read as signed: the MSB says "counter is behind".
  assign sinceStart  = frc - startQ;
  assign sinceEnd    = frc - endQ;
  assign beforeStart = sinceStart[TIME_W-1];
  assign beforeEnd   = sinceEnd[TIME_W-1];

  assign armed  = enable && (periodQ != '0);
  assign active = armed && !beforeStart && beforeEnd;
  assign rearm  = armed && !beforeEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodQ <= '0;
      startQ  <= '0;
      endQ    <= '0;
    end else begin
      if (wrPeriod) periodQ <= wrData;

      if (wrStart)    startQ <= wrData;
      else if (rearm) startQ <= startQ + periodQ;

      if (wrEnd)      endQ <= wrData;
      else if (rearm) endQ <= endQ + periodQ;
    end
  end

endmodule

// File: rtl/mask_ctrl.sv
// Control side: register decode, global enable, window slots and the
// combined block strobe handed to the datapath.
module mask_ctrl
  import dma_window_gate_pkg::*;
#(
  parameter int TIME_W  = 32,
  parameter int NUM_WIN = 2,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] frc,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [TIME_W-1:0] cfgWdata,
  output gateCtl_t          ctl
);

  localparam int REGS_PER_WIN = 3;

  logic               enableQ;
  logic [NUM_WIN-1:0] winActive;

  always_ff @(posedge clk) begin
    if (!rstN)                              enableQ <= 1'b0;
    else if (cfgWe && cfgAddr == '0)        enableQ <= cfgWdata[0];
  end

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    localparam int BASE = 1 + REGS_PER_WIN * k;
    logic wrPeriod;
    logic wrStart;
    logic wrEnd;

    assign wrPeriod = cfgWe && (cfgAddr == ADDR_W'(BASE));
    assign wrStart  = cfgWe && (cfgAddr == ADDR_W'(BASE + 1));
    assign wrEnd    = cfgWe && (cfgAddr == ADDR_W'(BASE + 2));

    window_slot #(.TIME_W(TIME_W)) u_slot (
      .clk      (clk),
      .rstN     (rstN),
      .enable   (enableQ),
      .frc      (frc),
      .wrPeriod (wrPeriod),
      .wrStart  (wrStart),
      .wrEnd    (wrEnd),
      .wrData   (cfgWdata),
      .active   (winActive[k])
    );
  end

  assign ctl.block = |winActive;

endmodule

// File: rtl/stream_gate.sv
// Datapath: passes the packet stream and refuses only packet starts
// while the control asks to block.
module stream_gate
  import dma_window_gate_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateCtl_t          ctl,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic              inSop,
  input  logic              inEop,
  output logic              inReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outSop,
  output logic              outEop,
  input  logic              outReady
);

  logic inPacket;
  logic allow;
  logic take;

  // Inside a packet the mask is never consulted.
  assign allow    = inPacket || !ctl.block;
  assign outValid = inValid && allow;
  assign inReady  = outReady && allow;
  assign outData  = inData;
  assign outSop   = inSop;
  assign outEop   = inEop;
  assign take     = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inPacket <= 1'b0;
    end else if (take) begin
      if (inEop)      inPacket <= 1'b0;
      else if (inSop) inPacket <= 1'b1;
    end
  end

endmodule

// File: rtl/dma_window_gate.sv
module dma_window_gate
  import dma_window_gate_pkg::*;
#(
  parameter int TIME_W  = 32,
  parameter int NUM_WIN = 2,
  parameter int DATA_W  = 16,
  localparam int ADDR_W = $clog2(1 + 3 * NUM_WIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] frc,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [TIME_W-1:0] cfgWdata,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic              inSop,
  input  logic              inEop,
  output logic              inReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outSop,
  output logic              outEop,
  input  logic              outReady
);

  gateCtl_t gateCtl;

  mask_ctrl #(
    .TIME_W  (TIME_W),
    .NUM_WIN (NUM_WIN),
    .ADDR_W  (ADDR_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .frc      (frc),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgWdata (cfgWdata),
    .ctl      (gateCtl)
  );

  stream_gate #(.DATA_W(DATA_W)) u_gate (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (gateCtl),
    .inValid  (inValid),
    .inData   (inData),
    .inSop    (inSop),
    .inEop    (inEop),
    .inReady  (inReady),
    .outValid (outValid),
    .outData  (outData),
    .outSop   (outSop),
    .outEop   (outEop),
    .outReady (outReady)
  );

endmodule

// File: rtl/dma_window_gate_chk.sv
module dma_window_gate_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              block,
  input logic              inValid,
  input logic [DATA_W-1:0] inData,
  input logic              inSop,
  input logic              inEop,
  input logic              inReady,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              outReady
);

  // Independent packet tracker built from the port handshake only.
  logic chkPkt;
  always_ff @(posedge clk) begin
    if (!rstN) chkPkt <= 1'b0;
    else if (inValid && inReady) begin
      if (inEop)      chkPkt <= 1'b0;
      else if (inSop) chkPkt <= 1'b1;
    end
  end

  p_sink_needed_r1: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> outReady);

  p_out_from_in_r1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (inValid && outData == inData));

  p_sop_held_r2: assert property (@(posedge clk) disable iff (!rstN)
    (block && !chkPkt && inValid && inSop) |-> (!inReady && !outValid));

  p_midpacket_free_r3: assert property (@(posedge clk) disable iff (!rstN)
    (chkPkt && inValid && outReady) |-> (inReady && outValid));

  p_open_when_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!block && inValid && outReady) |-> inReady);

endmodule

bind dma_window_gate dma_window_gate_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .block    (gateCtl.block),
  .inValid  (inValid),
  .inData   (inData),
  .inSop    (inSop),
  .inEop    (inEop),
  .inReady  (inReady),
  .outValid (outValid),
  .outData  (outData),
  .outReady (outReady)
);

// File: tb/dma_window_gate_tb.sv
module dma_window_gate_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TIME_W  = 32;
  localparam int NUM_WIN = 2;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = $clog2(1 + 3 * NUM_WIN);

  logic              clk = 1'b0;
  logic              rstN;
  logic [TIME_W-1:0] frc;
  logic              cfgWe;
  logic [ADDR_W-1:0] cfgAddr;
  logic [TIME_W-1:0] cfgWdata;
  logic              inValid;
  logic [DATA_W-1:0] inData;
  logic              inSop;
  logic              inEop;
  logic              inReady;
  logic              outValid;
  logic [DATA_W-1:0] outData;
  logic              outSop;
  logic              outEop;
  logic              outReady;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_window_gate #(
    .TIME_W  (TIME_W),
    .NUM_WIN (NUM_WIN),
    .DATA_W  (DATA_W)
  ) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .frc      (frc),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgWdata (cfgWdata),
    .inValid  (inValid),
    .inData   (inData),
    .inSop    (inSop),
    .inEop    (inEop),
    .inReady  (inReady),
    .outValid (outValid),
    .outData  (outData),
    .outSop   (outSop),
    .outEop   (outEop),
    .outReady (outReady)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; frc = '0; cfgWe = 1'b0; cfgAddr = '0; cfgWdata = '0;
    inValid = 1'b0; inData = '0; inSop = 1'b0; inEop = 1'b0; outReady = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic cfgWrite(input int addr, input logic [TIME_W-1:0] data);
    cfgWe = 1'b1; cfgAddr = ADDR_W'(addr); cfgWdata = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic setWindow(input int k, input logic [TIME_W-1:0] st,
                           input logic [TIME_W-1:0] en, input logic [TIME_W-1:0] per);
    cfgWrite(1 + 3 * k + 1, st);
    cfgWrite(1 + 3 * k + 2, en);
    cfgWrite(1 + 3 * k, per);
  endtask

  // At a negedge: set the counter, offer a one-beat packet, check, retire.
  task automatic probe(input string tag, input logic [TIME_W-1:0] t, input logic expPass);
    frc = t;
    inValid = 1'b1; inSop = 1'b1; inEop = 1'b1; inData = t[DATA_W-1:0] ^ 16'h5a5a;
    outReady = 1'b1;
    #2;
    check({tag, " inReady"}, inReady, expPass);
    check({tag, " outValid"}, outValid, expPass);
    @(negedge clk);
    inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    doReset();
    #2;
    check("R10 outValid idle", outValid, 1'b0);
    inValid = 1'b1; inSop = 1'b1; inEop = 1'b0; inData = 16'hbeef; outReady = 1'b0;
    #1;
    check("R1 ready follows sink low", inReady, 1'b0);
    outReady = 1'b1;
    #1;
    check("R1 ready follows sink high", inReady, 1'b1);
    check("R1 data copy", outData, 16'hbeef);
    check("R1 sop copy", outSop, 1'b1);
    check("R1 eop copy", outEop, 1'b0);
    inValid = 1'b0; inSop = 1'b0;
    @(negedge clk);
    probe("R10 no window after reset", 32'd150, 1'b1);
  endtask

  task automatic t_enable();
    doReset();
    setWindow(0, 32'd100, 32'd200, 32'd1000);
    probe("R8 enable clear no block", 32'd150, 1'b1);
    frc = '0;
    cfgWrite(0, 32'd1);
    probe("R8 enable set blocks", 32'd150, 1'b0);
  endtask

  task automatic t_period_zero();
    doReset();
    cfgWrite(0, 32'd1);
    setWindow(0, 32'd100, 32'd200, 32'd0);
    probe("R9 period zero no block", 32'd150, 1'b1);
  endtask

  task automatic t_window();
    doReset();
    cfgWrite(0, 32'd1);
    setWindow(0, 32'd100, 32'd120, 32'd1000);
    probe("R2 before start", 32'd99, 1'b1);
    probe("R2 at start", 32'd100, 1'b0);
    probe("R2 last inside", 32'd119, 1'b0);
    probe("R4 at end resumes", 32'd120, 1'b1);
    probe("R5 old window gone", 32'd110, 1'b1);
    probe("R5 next period blocks", 32'd1100, 1'b0);
    probe("R5 next period ends", 32'd1120, 1'b1);
  endtask

  task automatic t_inflight();
    doReset();
    cfgWrite(0, 32'd1);
    setWindow(0, 32'd100, 32'd200, 32'd1000);
    frc = 32'd50; outReady = 1'b1;
    inValid = 1'b1; inSop = 1'b1; inEop = 1'b0; inData = 16'h1111;
    #2;
    check("R3 sop before window", inReady, 1'b1);
    @(negedge clk);
    frc = 32'd150; inSop = 1'b0; inData = 16'h2222;
    #2;
    check("R3 middle beat in window", inReady, 1'b1);
    check("R3 middle beat out", outValid, 1'b1);
    @(negedge clk);
    inEop = 1'b1; inData = 16'h3333;
    #2;
    check("R3 eop beat in window", inReady, 1'b1);
    @(negedge clk);
    inSop = 1'b1; inEop = 1'b1; inData = 16'h4444;
    #2;
    check("R2 next sop held", inReady, 1'b0);
    check("R2 next sop not out", outValid, 1'b0);
    @(negedge clk);
    inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_wrap();
    doReset();
    frc = 32'hffff_ff00;
    cfgWrite(0, 32'd1);
    setWindow(0, 32'hffff_fff0, 32'h0000_0010, 32'h0000_1000);
    probe("R6 far before start", 32'hffff_ff00, 1'b1);
    probe("R6 before rollover", 32'hffff_fff8, 1'b0);
    probe("R6 after rollover", 32'h0000_0005, 1'b0);
    probe("R6 end after rollover", 32'h0000_0010, 1'b1);
  endtask

  task automatic t_multi();
    doReset();
    cfgWrite(0, 32'd1);
    setWindow(0, 32'd100, 32'd150, 32'd1000);
    setWindow(1, 32'd300, 32'd350, 32'd1000);
    probe("R7 first window", 32'd120, 1'b0);
    probe("R7 between windows", 32'd200, 1'b1);
    probe("R11 second window map", 32'd320, 1'b0);
    probe("R7 after both", 32'd400, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_enable();
    t_period_zero();
    t_window();
    t_inflight();
    t_wrap();
    t_multi();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule